// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind a write-strobe parallel bus and turns multi-cycle write sequences into operations on a small model of a flash array. The bus is sampled by a synchronous clock. The active-low write strobe passes through a synchronizer. Address and data are captured on each strobe assertion. A command fires on the release of the strobe that closes it. The recognised commands are word program, which takes four bus cycles, and three erase commands of six bus cycles each: one for a sector, one for a plane and one for the whole array.

An execution engine takes a fired command, raises `busy` for a fixed number of clock cycles and applies the result when it completes. It then drops `busy` and the block is back in read mode. A per-sector lock vector supplied from outside is sampled when the command fires. Locked sectors are never erased or programmed. Erase sets every bit to 1. Programming can only clear bits. A reset while an erase is running aborts it and leaves the targeted words holding a fixed junk value.

The bus and the read port carry no valid/ready handshake, because the strobe timing is set by the external master and the array read is purely combinational. Every pin is a plain control or data signal.

Top module: `flash_cmd_seq`

## Requirements
- R1: An erased word reads as all ones (8'hFF).
- R2: A program operation stores old_word & new_data in the target word, so it never turns a 0 bit into a 1.
- R3: Word program is the bus sequence 555/AA, 2AA/55, 555/A0, followed by a fourth cycle whose address (low 6 bits) and data name the target word and its value. Addresses are 11-bit hex and data is 8-bit hex.
- R4: Sector erase is the bus sequence 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55, then any address with data 30. The sector is address bits [5:3] of that sixth cycle. All 8 words of that sector are erased unless its lock bit is set, in which case nothing changes.
- R5: Plane erase is the same sequence with data 20 in the sixth cycle. The plane is address bits [5:4] of that cycle, and plane p holds sectors 2p and 2p+1. Both sectors are erased only if neither is locked. Otherwise nothing changes.
- R6: Chip erase is the same sequence with 555/10 in the sixth cycle. It erases every unlocked sector and leaves locked sectors unchanged.
- R7: A bus cycle that does not match the expected step of a sequence returns the decoder to its idle state, so the remaining cycles of that sequence have no effect.
- R8: `busy` rises a fixed number of clocks after the strobe that ends a valid command is released. It stays high for exactly EXEC_CYCLES clock cycles. The effect of the command is readable once it falls.
- R9: Bus cycles that arrive while `busy` is high are ignored, and no new command can start.
- R10: A reset during an erase clears `busy` and fills every word of the sectors that erase targeted with the GARBAGE value (default 8'h5A). Words in the other sectors are unchanged.
- R11: A program aimed at a word in a locked sector leaves that word unchanged.
- R12: After reset `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts a running operation |
| bus_addr | input | 11 | Bus address, captured on strobe assertion |
| bus_data | input | 8 | Bus data, captured on strobe assertion |
| bus_we_n | input | 1 | Active-low write strobe |
| sect_lock | input | 8 | One lock bit per sector; 1 = protected |
| rd_addr | input | 6 | Array read address |
| rd_data | output | 8 | Array word at rd_addr (combinational) |
| busy | output | 1 | High while an operation executes |

## Verification
The assertions assume that each strobe phase, low or high, lasts at least SYNC_STAGES+1 clocks, so that every edge is seen exactly once. They also assume that address and data are stable from before strobe assertion until the synchronized edge is taken. The bench drives every bus cycle with four-clock low and high phases and changes address and data only while the strobe is high. The lock vector is changed only while the block is idle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BUS_AW = 11;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [BUS_AW-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [BUS_DW-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [BUS_DW-1:0] KEY_DATA_B = 8'h55;
  localparam logic [BUS_DW-1:0] CODE_PROG   = 8'hA0;
  localparam logic [BUS_DW-1:0] CODE_ESETUP = 8'h80;
  localparam logic [BUS_DW-1:0] CODE_CHIP   = 8'h10;
  localparam logic [BUS_DW-1:0] CODE_SECT   = 8'h30;
  localparam logic [BUS_DW-1:0] CODE_PLANE  = 8'h20;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_PLANE = 2'd2,
    OP_CHIP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_C2, ST_C3, ST_P4, ST_E4, ST_E5, ST_E6
  } seq_st_e;
endpackage

// File: rtl/flash_we_sync.sv
module flash_we_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], we_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
  assign rise = ~prev & chain[STAGES-1];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              rise,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] data,
  input  logic              busy,
  output logic              start,
  output op_e               op,
  output logic [ARR_AW-1:0] op_addr,
  output logic [BUS_DW-1:0] op_data
);
  seq_st_e st, st_nxt;
  logic    fire;
  op_e     fire_op;
  logic    armed;
  logic    hit_a, hit_b, at_key_a;

  assign at_key_a = (addr == KEY_ADDR_A);
  assign hit_a    = at_key_a && (data == KEY_DATA_A);
  assign hit_b    = (addr == KEY_ADDR_B) && (data == KEY_DATA_B);

  always_comb begin
    st_nxt  = ST_IDLE;
    fire    = 1'b0;
    fire_op = OP_PROG;
    unique case (st)
      ST_IDLE: st_nxt = hit_a ? ST_C2 : ST_IDLE;
      ST_C2:   st_nxt = hit_b ? ST_C3 : ST_IDLE;
      ST_C3: begin
        if (at_key_a && data == CODE_PROG)        st_nxt = ST_P4;
        else if (at_key_a && data == CODE_ESETUP) st_nxt = ST_E4;
      end
      ST_P4: fire = 1'b1;
      ST_E4: st_nxt = hit_a ? ST_E5 : ST_IDLE;
      ST_E5: st_nxt = hit_b ? ST_E6 : ST_IDLE;
      ST_E6: begin
        if (at_key_a && data == CODE_CHIP) begin
          fire = 1'b1; fire_op = OP_CHIP;
        end else if (data == CODE_SECT) begin
          fire = 1'b1; fire_op = OP_SECT;
        end else if (data == CODE_PLANE) begin
          fire = 1'b1; fire_op = OP_PLANE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      armed   <= 1'b0;
      start   <= 1'b0;
      op      <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      start <= 1'b0;
      if (busy) begin
        st    <= ST_IDLE;
        armed <= 1'b0;
      end else begin
        if (fall) begin
          st <= st_nxt;
          if (fire) begin
            armed   <= 1'b1;
            op      <= fire_op;
            op_addr <= addr[ARR_AW-1:0];
            op_data <= data;
          end
        end
        if (rise && armed) begin
          start <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/flash_exec_array.sv
module flash_exec_array
  import flash_cmd_pkg::*;
#(
  parameter int              SECT_PP_LOG = 1,
  parameter int              WORD_LOG    = 3,
  parameter int              EXEC_CYCLES = 16,
  parameter logic [BUS_DW-1:0] GARBAGE   = 8'h5A,
  localparam int             PLANE_W     = 2,
  localparam int             SECT_W      = PLANE_W + SECT_PP_LOG,
  localparam int             ARR_AW      = SECT_W + WORD_LOG,
  localparam int             NUM_SECT    = 1 << SECT_W,
  localparam int             DEPTH       = 1 << ARR_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  op_e                 op,
  input  logic [ARR_AW-1:0]   op_addr,
  input  logic [BUS_DW-1:0]   op_data,
  input  logic [NUM_SECT-1:0] lock,
  input  logic [ARR_AW-1:0]   rd_addr,
  output logic [BUS_DW-1:0]   rd_data,
  output logic                busy
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  logic [BUS_DW-1:0]   mem [DEPTH];
  logic [CNT_W-1:0]    cnt;
  op_e                 cur_op;
  logic [ARR_AW-1:0]   tgt;
  logic [BUS_DW-1:0]   wdat;
  logic [NUM_SECT-1:0] mask_q, mask_d, plane_mask, sect_hot;
  logic [SECT_W-1:0]   in_sect;
  logic [PLANE_W-1:0]  in_plane;
  logic                done;

  assign in_sect  = op_addr[ARR_AW-1:WORD_LOG];
  assign in_plane = op_addr[ARR_AW-1 -: PLANE_W];
  assign done     = busy && (cnt == '0);

  always_comb begin
    plane_mask = '0;
    sect_hot   = '0;
    for (int s = 0; s < NUM_SECT; s++)
      plane_mask[s] = ((s >> SECT_PP_LOG) == int'(in_plane));
    sect_hot[in_sect] = 1'b1;
    unique case (op)
      OP_PROG, OP_SECT: mask_d = sect_hot & ~lock;
      OP_PLANE:         mask_d = ((plane_mask & lock) == '0) ? plane_mask : '0;
      default:          mask_d = ~lock;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cur_op <= OP_PROG;
      tgt    <= '0;
      wdat   <= '0;
      mask_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(EXEC_CYCLES - 1);
      cur_op <= op;
      tgt    <= op_addr;
      wdat   <= op_data;
      mask_q <= mask_d;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (busy && cur_op != OP_PROG)
        for (int w = 0; w < DEPTH; w++)
          if (mask_q[w >> WORD_LOG]) mem[w] <= GARBAGE;
    end else if (done) begin
      if (cur_op == OP_PROG) begin
        if (mask_q[tgt[ARR_AW-1:WORD_LOG]]) mem[tgt] <= mem[tgt] & wdat;
      end else begin
        for (int w = 0; w < DEPTH; w++)
          if (mask_q[w >> WORD_LOG]) mem[w] <= '1;
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int                SECT_PP_LOG = 1,
  parameter int                WORD_LOG    = 3,
  parameter int                EXEC_CYCLES = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BUS_DW-1:0] GARBAGE     = 8'h5A,
  localparam int               ARR_AW      = 2 + SECT_PP_LOG + WORD_LOG,
  localparam int               NUM_SECT    = 1 << (2 + SECT_PP_LOG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BUS_DW-1:0]   bus_data,
  input  logic                bus_we_n,
  input  logic [NUM_SECT-1:0] sect_lock,
  input  logic [ARR_AW-1:0]   rd_addr,
  output logic [BUS_DW-1:0]   rd_data,
  output logic                busy
);
  logic              we_fall, we_rise, seq_start;
  op_e               seq_op;
  logic [ARR_AW-1:0] seq_addr;
  logic [BUS_DW-1:0] seq_data;

  flash_we_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .we_n(bus_we_n), .fall(we_fall), .rise(we_rise)
  );

  flash_cmd_decode #(.ARR_AW(ARR_AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .fall(we_fall), .rise(we_rise),
    .addr(bus_addr), .data(bus_data), .busy(busy),
    .start(seq_start), .op(seq_op), .op_addr(seq_addr), .op_data(seq_data)
  );

  flash_exec_array #(
    .SECT_PP_LOG(SECT_PP_LOG), .WORD_LOG(WORD_LOG),
    .EXEC_CYCLES(EXEC_CYCLES), .GARBAGE(GARBAGE)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .op(seq_op),
    .op_addr(seq_addr), .op_data(seq_data), .lock(sect_lock),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int EXEC_CYCLES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic start
);
  localparam int RW = $clog2(EXEC_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  // R8: execution begins the cycle after the start pulse
  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R8: busy never outlasts the configured window and ends exactly at it
  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(EXEC_CYCLES));

  assert_busy_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < RW'(EXEC_CYCLES));

  // R9: no command is launched while an operation executes
  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R3: a start pulse lasts one cycle
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R12: leaving reset, the block is idle
  assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.EXEC_CYCLES(EXEC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(seq_start)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int EXEC = 100;
  localparam int DEPTH = 64;
  localparam logic [7:0] JUNK = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_we_n = 1'b1;
  logic [7:0]  sect_lock = '0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  flash_cmd_seq #(.EXEC_CYCLES(EXEC), .GARBAGE(JUNK)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_we_n(bus_we_n), .sect_lock(sect_lock), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  typedef struct { int a; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  logic [7:0] ref_mem [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit mon_busy = 0;
  int run = 0, last_run = 0;

  task automatic note(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words and compares the read port
  initial forever begin
    item_t it;
    wait (q.size() > 0);
    mon_busy = 1;
    it = q.pop_front();
    @(negedge clk) rd_addr = 6'(it.a);
    @(negedge clk) note(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
    mon_busy = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) run = 0;
    else if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic check_all(string tag);
    for (int w = 0; w < DEPTH; w++) q.push_back('{w, ref_mem[w], tag});
    wait (q.size() == 0 && !mon_busy);
    @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_we_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_prog(input int a, input logic [7:0] d);
    bus_cycle(11'h555, 8'hAA); bus_cycle(11'h2AA, 8'h55);
    bus_cycle(11'h555, 8'hA0); bus_cycle(11'(a), d);
  endtask

  task automatic do_erase(input logic [10:0] a, input logic [7:0] code);
    bus_cycle(11'h555, 8'hAA); bus_cycle(11'h2AA, 8'h55);
    bus_cycle(11'h555, 8'h80); bus_cycle(11'h555, 8'hAA);
    bus_cycle(11'h2AA, 8'h55); bus_cycle(a, code);
  endtask

  function automatic void m_prog(int a, logic [7:0] d);
    if (!sect_lock[a >> 3]) ref_mem[a] = ref_mem[a] & d;
  endfunction

  function automatic void m_fill(logic [7:0] m, logic [7:0] v);
    for (int w = 0; w < DEPTH; w++) if (m[w >> 3]) ref_mem[w] = v;
  endfunction

  function automatic logic [7:0] plane_sects(int p);
    return 8'(2'b11 << (2 * p));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(busy == 1'b0, "R12 busy after reset", int'(busy), 0);

    // R6 / R1: chip erase with nothing locked
    do_erase(11'h555, 8'h10); wait_idle();
    m_fill(8'hFF, 8'hFF);
    check_all("R6/R1 chip erase all ones");

    // R2 / R3: program, then reprogram only clears bits
    do_prog(5, 8'h3C); wait_idle(); m_prog(5, 8'h3C);
    note(last_run == EXEC, "R8 busy length", last_run, EXEC);
    do_prog(5, 8'hF0); wait_idle(); m_prog(5, 8'hF0);
    q.push_back('{5, 8'h30, "R2 and of old and new"});
    check_all("R3 program");

    // R3: fill the array with a pattern
    for (int w = 0; w < DEPTH; w++) begin
      do_prog(w, 8'(w * 5 + 3)); wait_idle(); m_prog(w, 8'(w * 5 + 3));
    end
    check_all("R3 pattern fill");

    // R11: locked sector ignores program
    sect_lock = 8'b0000_0100;
    do_prog(6'h12, 8'h00); wait_idle(); m_prog(6'h12, 8'h00);
    check_all("R11 locked program");

    // R4: sector erase, unlocked then locked
    do_erase(11'h70B, 8'h30); wait_idle(); m_fill(8'b0000_0010, 8'hFF);
    check_all("R4 sector erase");
    do_erase(11'h013, 8'h30); wait_idle();
    check_all("R4 locked sector untouched");

    // R5: plane with a locked sector, then a clean plane
    do_erase(11'h01A, 8'h20); wait_idle();
    check_all("R5 locked plane untouched");
    do_erase(11'h035, 8'h20); wait_idle(); m_fill(plane_sects(3), 8'hFF);
    check_all("R5 plane erase");

    // R7: a broken sequence does nothing
    bus_cycle(11'h555, 8'hAA); bus_cycle(11'h2AA, 8'h00);
    bus_cycle(11'h555, 8'hA0); bus_cycle(11'h020, 8'h00);
    repeat (10) @(negedge clk);
    note(busy == 1'b0, "R7 no start", int'(busy), 0);
    check_all("R7 mismatch");

    // R9: program issued while an erase runs is dropped
    do_erase(11'h003, 8'h30);
    note(busy == 1'b1, "R9 busy during erase", int'(busy), 1);
    do_prog(6'h28, 8'h00);
    wait_idle(); m_fill(8'b0000_0001, 8'hFF);
    repeat (10) @(negedge clk);
    check_all("R9 ignored while busy");

    // R10: reset aborts a chip erase
    sect_lock = 8'b1000_0100;
    do_erase(11'h555, 8'h10);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(busy == 1'b0, "R10 busy cleared", int'(busy), 0);
    m_fill(~sect_lock, JUNK);
    check_all("R10 abort junk");

    // R6: chip erase skips locked sectors
    do_erase(11'h555, 8'h10); wait_idle(); m_fill(~sect_lock, 8'hFF);
    check_all("R6 locked kept");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule